// File: doc/BRIEF.md
# Paging Address Translator with Tagged Lookaside Buffer

This block turns a logical address into a physical address for a single-level paged memory. Each request carries a logical address and an address-space tag that names the running process. The upper bits of the address select a page and the lower bits are the offset within it. The page is looked up at once in a small fully associative lookaside buffer. Every entry there is keyed on both the page and the address-space tag, so entries that belong to different processes can be held side by side.

On a hit, the physical address is the cached frame number with the unchanged offset appended, and the answer comes back one cycle after the request is accepted. On a miss, the block reads one page-table word through a read-only memory port. That word sits at the table base register plus the page number. The block then installs the mapping and answers. A table length register bounds the walk. A page number outside it, or a table word whose valid bit is clear, gives a fault response. A flush input empties the buffer for systems that do not assign distinct tags.

Top module: `mmu_paging_top`

## Requirements
- R1: The physical address is the 20-bit frame number in bits 31:12 followed by the 12 offset bits of the logical address, copied unchanged into bits 11:0.
- R2: When the tag and page number match a valid buffer entry, `rsp_valid` is high in the cycle after acceptance and no table read is issued.
- R3: A buffer hit needs both the address-space tag and the page number to match. The same page under a different tag misses and walks.
- R4: On a miss, exactly one table read is issued, at address `base + page`. The response comes three cycles after acceptance, and the mapping is installed, so the next identical request hits.
- R5: A page number greater than or equal to the length register gives a fault response in the cycle after acceptance, with `rsp_pa` zero and no table read. This check takes priority over the buffer lookup.
- R6: A table word has its valid bit in bit 20 and its frame number in bits 19:0. If the fetched word has bit 20 clear, the response is a fault with `rsp_pa` zero, nothing is installed, and a repeat of the request walks again.
- R7: `tlb_flush` clears every buffer entry in one cycle. If a flush and an install fall on the same edge, the flush wins: the walk still answers correctly but the mapping is not kept.
- R8: An install uses the lowest-numbered empty entry when one exists. Otherwise it replaces the entry under a round-robin pointer, which then advances.
- R9: `req_ready` is low from acceptance of a missing request until its response, so only one translation is in flight at a time.
- R10: After reset, `req_ready` is high, `rsp_valid` and `pt_rd_en` are low, the buffer is empty, and both table registers are zero, so every request faults until the length register is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_la | input | 32 | Logical address |
| req_asid | input | 8 | Address-space tag of the requester |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_pa | output | 32 | Physical address (zero on fault) |
| rsp_fault | output | 1 | Response is a fault |
| tbl_base_ld | input | 1 | Load table base register from `tbl_wdata` |
| tbl_len_ld | input | 1 | Load table length register from `tbl_wdata` |
| tbl_wdata | input | 32 | Register load value |
| tlb_flush | input | 1 | Invalidate all buffer entries |
| pt_rd_en | output | 1 | Table read strobe |
| pt_rd_addr | output | 32 | Table word address |
| pt_rd_data | input | 21 | Table word, valid one cycle after the strobe |

## Verification
A flush and the install at the end of a walk can fall on the same clock edge. The bench provokes this by raising `tlb_flush` during the cycle in which the fetched table word is present. It then checks two things: the pending response still carries the correct frame, and a repeat of the same request issues a fresh table read instead of hitting. Replacement order is judged the same way from outside. The bench counts table reads to tell hits from misses after the buffer has been filled past its capacity.

// File: rtl/mmu_pkg.sv
package mmu_pkg;

    localparam int LA_W      = 32;
    localparam int PAGE_BITS = 12;
    localparam int ASID_W    = 8;
    localparam int PTA_W     = 32;
    localparam int TLB_N     = 16;

    localparam int VPN_W   = LA_W - PAGE_BITS;
    localparam int FRAME_W = VPN_W;
    localparam int PA_W    = FRAME_W + PAGE_BITS;
    localparam int PTE_W   = FRAME_W + 1;

    typedef logic [VPN_W-1:0]     vpn_t;
    typedef logic [FRAME_W-1:0]   frame_t;
    typedef logic [PAGE_BITS-1:0] offs_t;
    typedef logic [ASID_W-1:0]    asid_t;
    typedef logic [PTA_W-1:0]     pta_t;
    typedef logic [PA_W-1:0]      pa_t;

    // Table word layout: valid flag above the frame number
    typedef struct packed {
        logic   valid;
        frame_t frame;
    } pte_t;

    typedef struct packed {
        asid_t  asid;
        vpn_t   vpn;
        frame_t frame;
    } tlb_entry_t;

    typedef enum logic [1:0] {
        W_IDLE = 2'd0,
        W_READ = 2'd1,
        W_WAIT = 2'd2
    } walk_state_e;

    function automatic vpn_t la_vpn(input logic [LA_W-1:0] la);
        return la[LA_W-1:PAGE_BITS];
    endfunction

    function automatic offs_t la_off(input logic [LA_W-1:0] la);
        return la[PAGE_BITS-1:0];
    endfunction

    function automatic pa_t make_pa(input frame_t fr, input offs_t off);
        return {fr, off};
    endfunction

endpackage

// File: rtl/mmu_tlb.sv
module mmu_tlb
    import mmu_pkg::*;
#(
    parameter int N = TLB_N
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   flush,
    input  asid_t  lk_asid,
    input  vpn_t   lk_vpn,
    output logic   lk_hit,
    output frame_t lk_frame,
    input  logic   fill_en,
    input  asid_t  fill_asid,
    input  vpn_t   fill_vpn,
    input  frame_t fill_frame
);
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

    tlb_entry_t       ent_q [N];
    logic [N-1:0]     vld_q;
    logic [N-1:0]     match;
    logic [N-1:0]     fill_sel;
    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] victim;
    logic             any_free;

    // Parallel compare of every entry against tag and page
    generate
        for (genvar i = 0; i < N; i++) begin : g_ent
            assign match[i] = vld_q[i]
                           && (ent_q[i].asid == lk_asid)
                           && (ent_q[i].vpn  == lk_vpn);
            assign fill_sel[i] = fill_en && !flush && (victim == IDX_W'(i));

            always_ff @(posedge clk) begin
                if (fill_sel[i]) begin
                    ent_q[i] <= '{asid: fill_asid, vpn: fill_vpn, frame: fill_frame};
                end
            end
        end
    endgenerate

    always_comb begin
        lk_hit   = |match;
        lk_frame = '0;
        for (int i = 0; i < N; i++) begin
            if (match[i]) lk_frame = lk_frame | ent_q[i].frame;
        end
    end

    // Lowest empty slot first, otherwise the round-robin slot
    always_comb begin
        any_free = 1'b0;
        victim   = rr_q;
        for (int i = N - 1; i >= 0; i--) begin
            if (!vld_q[i]) begin
                any_free = 1'b1;
                victim   = IDX_W'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
            rr_q  <= '0;
        end else if (flush) begin
            vld_q <= '0;
        end else if (fill_en) begin
            vld_q[victim] <= 1'b1;
            if (!any_free) begin
                rr_q <= (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + 1'b1;
            end
        end
    end

    a_r7_flush_empties: assert property (@(posedge clk) disable iff (rst)
        flush |=> (vld_q == '0));

    a_r3_single_match: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match));

    a_r8_one_slot_written: assert property (@(posedge clk) disable iff (rst)
        $onehot0(fill_sel));

    a_r8_pointer_waits_for_full: assert property (@(posedge clk) disable iff (rst)
        (fill_en && any_free) |=> $stable(rr_q));

endmodule

// File: rtl/mmu_walker.sv
module mmu_walker
    import mmu_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  logic [LA_W-1:0] req_la,
    input  asid_t           req_asid,
    output logic            req_ready,
    input  logic            lk_hit,
    input  frame_t          lk_frame,
    input  pta_t            base_q,
    input  pta_t            len_q,
    output logic            pt_rd_en,
    output pta_t            pt_rd_addr,
    input  logic [PTE_W-1:0] pt_rd_data,
    output logic            fill_en,
    output asid_t           fill_asid,
    output vpn_t            fill_vpn,
    output frame_t          fill_frame,
    output logic            rsp_valid,
    output pa_t             rsp_pa,
    output logic            rsp_fault
);
    walk_state_e state_q;
    vpn_t        vpn_q;
    offs_t       off_q;
    asid_t       asid_q;
    pte_t        pte;
    logic        acc;
    logic        oor;
    vpn_t        req_vpn;

    assign req_vpn   = la_vpn(req_la);
    assign req_ready = (state_q == W_IDLE);
    assign acc       = req_valid && req_ready;
    assign oor       = (PTA_W'(req_vpn) >= len_q);
    assign pte       = pte_t'(pt_rd_data);

    assign pt_rd_en   = (state_q == W_READ);
    assign pt_rd_addr = base_q + PTA_W'(vpn_q);

    assign fill_en    = (state_q == W_WAIT) && pte.valid;
    assign fill_asid  = asid_q;
    assign fill_vpn   = vpn_q;
    assign fill_frame = pte.frame;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= W_IDLE;
            rsp_valid <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_pa    <= '0;
            vpn_q     <= '0;
            off_q     <= '0;
            asid_q    <= '0;
        end else begin
            rsp_valid <= 1'b0;
            case (state_q)
                W_IDLE: begin
                    if (acc) begin
                        if (oor) begin
                            rsp_valid <= 1'b1;
                            rsp_fault <= 1'b1;
                            rsp_pa    <= '0;
                        end else if (lk_hit) begin
                            rsp_valid <= 1'b1;
                            rsp_fault <= 1'b0;
                            rsp_pa    <= make_pa(lk_frame, la_off(req_la));
                        end else begin
                            vpn_q   <= req_vpn;
                            off_q   <= la_off(req_la);
                            asid_q  <= req_asid;
                            state_q <= W_READ;
                        end
                    end
                end
                W_READ: state_q <= W_WAIT;
                W_WAIT: begin
                    state_q   <= W_IDLE;
                    rsp_valid <= 1'b1;
                    rsp_fault <= !pte.valid;
                    rsp_pa    <= pte.valid ? make_pa(pte.frame, off_q) : '0;
                end
                default: state_q <= W_IDLE;
            endcase
        end
    end

    a_r2_hit_next_cycle: assert property (@(posedge clk) disable iff (rst)
        (acc && !oor && lk_hit) |=> (rsp_valid && !rsp_fault && !pt_rd_en));

    a_r5_range_fault: assert property (@(posedge clk) disable iff (rst)
        (acc && oor) |=> (rsp_valid && rsp_fault && !pt_rd_en && (rsp_pa == '0)));

    a_r4_single_read: assert property (@(posedge clk) disable iff (rst)
        pt_rd_en |=> !pt_rd_en);

    a_r4_answer_after_read: assert property (@(posedge clk) disable iff (rst)
        pt_rd_en |=> ##1 rsp_valid);

    a_r9_no_accept_in_walk: assert property (@(posedge clk) disable iff (rst)
        (acc && !oor && !lk_hit) |=> (!req_ready ##1 !req_ready));

endmodule

// File: rtl/mmu_paging_top.sv
module mmu_paging_top
    import mmu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [LA_W-1:0]   req_la,
    input  logic [ASID_W-1:0] req_asid,
    output logic              rsp_valid,
    output logic [PA_W-1:0]   rsp_pa,
    output logic              rsp_fault,
    input  logic              tbl_base_ld,
    input  logic              tbl_len_ld,
    input  logic [PTA_W-1:0]  tbl_wdata,
    input  logic              tlb_flush,
    output logic              pt_rd_en,
    output logic [PTA_W-1:0]  pt_rd_addr,
    input  logic [PTE_W-1:0]  pt_rd_data
);
    pta_t   base_q;
    pta_t   len_q;
    logic   lk_hit;
    frame_t lk_frame;
    logic   fill_en;
    asid_t  fill_asid;
    vpn_t   fill_vpn;
    frame_t fill_frame;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            len_q  <= '0;
        end else begin
            if (tbl_base_ld) base_q <= tbl_wdata;
            if (tbl_len_ld)  len_q  <= tbl_wdata;
        end
    end

    mmu_tlb #(.N(TLB_N)) u_tlb (
        .clk        (clk),
        .rst        (rst),
        .flush      (tlb_flush),
        .lk_asid    (req_asid),
        .lk_vpn     (la_vpn(req_la)),
        .lk_hit     (lk_hit),
        .lk_frame   (lk_frame),
        .fill_en    (fill_en),
        .fill_asid  (fill_asid),
        .fill_vpn   (fill_vpn),
        .fill_frame (fill_frame)
    );

    mmu_walker u_walk (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_la     (req_la),
        .req_asid   (req_asid),
        .req_ready  (req_ready),
        .lk_hit     (lk_hit),
        .lk_frame   (lk_frame),
        .base_q     (base_q),
        .len_q      (len_q),
        .pt_rd_en   (pt_rd_en),
        .pt_rd_addr (pt_rd_addr),
        .pt_rd_data (pt_rd_data),
        .fill_en    (fill_en),
        .fill_asid  (fill_asid),
        .fill_vpn   (fill_vpn),
        .fill_frame (fill_frame),
        .rsp_valid  (rsp_valid),
        .rsp_pa     (rsp_pa),
        .rsp_fault  (rsp_fault)
    );

    a_r6_fault_not_installed: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault) |-> !$past(fill_en));

    a_r9_read_only_when_busy: assert property (@(posedge clk) disable iff (rst)
        pt_rd_en |-> !req_ready);

endmodule

// File: tb/sim_mmu_paging_top.sv
module sim_mmu_paging_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] TBASE = 32'd16;
    localparam logic [31:0] TLEN  = 32'd200;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_la = '0;
    logic [7:0]  req_asid = '0;
    logic        rsp_valid;
    logic [31:0] rsp_pa;
    logic        rsp_fault;
    logic        tbl_base_ld = 1'b0;
    logic        tbl_len_ld = 1'b0;
    logic [31:0] tbl_wdata = '0;
    logic        tlb_flush = 1'b0;
    logic        pt_rd_en;
    logic [31:0] pt_rd_addr;
    logic [20:0] pt_rd_data = '0;

    int n_total = 0;
    int n_fail  = 0;
    int rd_cnt  = 0;
    logic [31:0] last_addr = '0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mmu_paging_top u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_la(req_la), .req_asid(req_asid), .rsp_valid(rsp_valid),
        .rsp_pa(rsp_pa), .rsp_fault(rsp_fault), .tbl_base_ld(tbl_base_ld),
        .tbl_len_ld(tbl_len_ld), .tbl_wdata(tbl_wdata), .tlb_flush(tlb_flush),
        .pt_rd_en(pt_rd_en), .pt_rd_addr(pt_rd_addr), .pt_rd_data(pt_rd_data)
    );

    // Table word model: bit 20 valid, bits 19:0 frame
    function automatic logic [20:0] pte_of(input logic [31:0] a);
        logic [31:0] f;
        f = a * 32'd37 + 32'd5;
        return {((a % 7) != 3), f[19:0]};
    endfunction

    always @(posedge clk) begin
        if (pt_rd_en) begin
            pt_rd_data <= pte_of(pt_rd_addr);
            last_addr  <= pt_rd_addr;
            rd_cnt     <= rd_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("  %0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    endtask

    task automatic xlate(input logic [7:0] asid, input logic [31:0] la,
                         output logic [31:0] pa, output logic flt,
                         output int lat, output int reads, output bit rdy_low);
        int r0;
        @(negedge clk);
        req_valid = 1'b1; req_la = la; req_asid = asid;
        while (!req_ready) @(negedge clk);
        r0 = rd_cnt;
        @(posedge clk); #1;
        req_valid = 1'b0;
        lat = 0; rdy_low = 1;
        do begin
            @(negedge clk);
            lat++;
            if (!rsp_valid && req_ready) rdy_low = 0;
        end while (!rsp_valid && lat < 10);
        pa = rsp_pa; flt = rsp_fault; reads = rd_cnt - r0;
    endtask

    function automatic logic [31:0] exp_pa(input logic [19:0] vpn, input logic [11:0] off);
        logic [20:0] p;
        p = pte_of(TBASE + 32'(vpn));
        return {p[19:0], off};
    endfunction

    // {asid, vpn, offset, expect_walk, expect_fault}
    localparam logic [41:0] VECS [10] = '{
        {8'd1, 20'd2,       12'h123, 1'b1, 1'b0},
        {8'd1, 20'd2,       12'hFFF, 1'b0, 1'b0},
        {8'd2, 20'd2,       12'h000, 1'b1, 1'b0},
        {8'd1, 20'd2,       12'h456, 1'b0, 1'b0},
        {8'd1, 20'd1,       12'h010, 1'b1, 1'b1},
        {8'd1, 20'd1,       12'h010, 1'b1, 1'b1},
        {8'd1, 20'd200,     12'h7A0, 1'b0, 1'b1},
        {8'd1, 20'd199,     12'h001, 1'b1, 1'b0},
        {8'd1, 20'hFFFFF,   12'h002, 1'b0, 1'b1},
        {8'd2, 20'd199,     12'hABC, 1'b1, 1'b0}
    };

    task automatic probe(input string tag, input logic [7:0] asid, input logic [19:0] vpn,
                         input logic [11:0] off, input bit walk, input bit fault);
        logic [31:0] pa; logic flt; int lat; int rd; bit rl;
        logic [31:0] epa;
        xlate(asid, {vpn, off}, pa, flt, lat, rd, rl);
        epa = fault ? 32'd0 : exp_pa(vpn, off);
        chk(pa == epa && flt == fault, {tag, " R1 pa/fault"}, {31'd0, flt, pa}, {31'd0, fault, epa});
        chk(rd == (walk ? 1 : 0), {tag, walk ? " R4 read count" : " R2 no read"}, 64'(rd), 64'(walk ? 1 : 0));
        chk(lat == (walk ? 3 : 1), {tag, " R2/R4 latency"}, 64'(lat), 64'(walk ? 3 : 1));
        if (walk) begin
            chk(last_addr == TBASE + 32'(vpn), {tag, " R4 table address"}, 64'(last_addr), 64'(TBASE + 32'(vpn)));
            chk(rl, {tag, " R9 ready low in walk"}, 64'(rl), 64'd1);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_total++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            report();
        end
    end

    initial begin
        logic [19:0] pg [13];
        int k;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk(req_ready == 1'b1, "R10 ready after reset", 64'(req_ready), 64'd1);
        chk(rsp_valid == 1'b0, "R10 no response after reset", 64'(rsp_valid), 64'd0);
        chk(pt_rd_en == 1'b0, "R10 no read after reset", 64'(pt_rd_en), 64'd0);
        probe("R10 zero length faults", 8'd1, 20'd0, 12'h123, 1'b0, 1'b1);

        @(negedge clk); tbl_wdata = TBASE; tbl_base_ld = 1'b1;
        @(negedge clk); tbl_base_ld = 1'b0; tbl_wdata = TLEN; tbl_len_ld = 1'b1;
        @(negedge clk); tbl_len_ld = 1'b0;

        // Vector table: hits, R3 tag separation, R5 range, R6 invalid word
        for (int i = 0; i < 10; i++) begin
            probe($sformatf("vec%0d R3/R5/R6", i), VECS[i][41:34], VECS[i][33:14],
                  VECS[i][13:2], VECS[i][1], VECS[i][0]);
        end

        // R8 replacement: 4 entries used, fill 12 more then one past capacity
        k = 0;
        for (int v = 30; k < 13; v++) begin
            if ((v % 7) != 1) begin pg[k] = 20'(v); k++; end
        end
        for (int j = 0; j < 13; j++) probe("R8 fill", 8'd3, pg[j], 12'h0, 1'b1, 1'b0);
        probe("R8 slot1 kept", 8'd2, 20'd2, 12'h111, 1'b0, 1'b0);
        probe("R8 slot0 evicted", 8'd1, 20'd2, 12'h222, 1'b1, 1'b0);
        probe("R8 slot1 evicted next", 8'd2, 20'd2, 12'h333, 1'b1, 1'b0);
        probe("R8 slot3 kept", 8'd2, 20'd199, 12'h444, 1'b0, 1'b0);
        probe("R8 newest kept", 8'd3, pg[12], 12'h555, 1'b0, 1'b0);

        // R7 flush while idle
        @(negedge clk); tlb_flush = 1'b1;
        @(negedge clk); tlb_flush = 1'b0;
        probe("R7 flushed entry walks", 8'd2, 20'd199, 12'h666, 1'b1, 1'b0);

        // R7 flush on the same edge as the install
        @(negedge clk);
        req_valid = 1'b1; req_asid = 8'd4; req_la = {20'd40, 12'h0AB};
        while (!req_ready) @(negedge clk);
        @(posedge clk); #1; req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk); tlb_flush = 1'b1;
        @(posedge clk); #1; tlb_flush = 1'b0;
        @(negedge clk);
        chk(rsp_valid && !rsp_fault && rsp_pa == exp_pa(20'd40, 12'h0AB),
            "R7 collision answer", {31'd0, rsp_valid, rsp_pa}, {31'd0, 1'b1, exp_pa(20'd40, 12'h0AB)});
        probe("R7 collision not kept", 8'd4, 20'd40, 12'h0AB, 1'b1, 1'b0);
        probe("R4 installed after walk", 8'd4, 20'd40, 12'h0CD, 1'b0, 1'b0);

        done = 1;
        report();
    end
endmodule